// File: doc/BRIEF.md
# Video Format Word Decoder

This block recovers the lines-per-field word that a sync separator sends serially on its format pin, and turns it into a video format code. The horizontal sync (active low) acts as the bit clock. The vertical sync (active low) marks where each word starts. Every field brings one new 11-bit word. Each bit is read in the middle of its line, well away from the data transitions. The read point comes from the length of the line just before, counted in system clocks.

The recovered count is compared against the known line counts of the supported formats, with a small tolerance. The result is a format code and a field identity for interlaced formats. A flag for the SD composite formats is taken straight from one bit of the word. The reported format changes only when two fields in a row agree, so a single corrupted word cannot make it flicker.

Top module: `vfd_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, count_o is 0, fmt_o is 0 (unknown), field_o is 0, sd_comp_o is 0 and valid_o is 0.
- R2: A word is captured MSB first, one bit per line. The first bit belongs to the third hsync_ni falling edge after the vsync_ni falling edge, and the next ten bits belong to the ten falling edges that follow. An hsync_ni falling edge in the same clock as the vsync_ni falling edge is not counted.
- R3: Each bit is sampled from data_i about half a line after its hsync_ni falling edge. Half a line means half the length, in clocks, of the horizontal period that has just ended.
- R4: Format codes on fmt_o are: 0 unknown, 1 for 525-line interlaced (259/260), 2 for 625-line interlaced (309/310), 3 for 480P (522), 4 for 576P (622), 5 for 720P (747), 6 for 1080I (559/560), 7 for 1080P (1122).
- R5: A word matches a format when it lies within 2 lines of that format's counts. For an interlaced format, field_o is 1 (field 1) when the word is at least the larger count, and 0 otherwise. For a progressive format, field_o is 1.
- R6: A word that matches no format gives field_o = 0 and produces no valid_o pulse.
- R7: fmt_o takes a new value only when the same code has been decoded from two consecutive words. This includes a return to unknown.
- R8: valid_o is high for exactly one clock, one clock after the eleventh bit is captured. count_o, field_o and sd_comp_o are updated from every completed word in that same edge.
- R9: sd_comp_o equals bit 8 of the word, which is the third bit from the MSB. It is 1 for the two SD composite formats and 0 for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, active low, used as bit clock |
| vsync_ni | input | 1 | Vertical sync, active low, marks start of word |
| data_i | input | 1 | Serial lines-per-field data |
| count_o | output | 11 | Last captured line count |
| fmt_o | output | 4 | Confirmed format code |
| field_o | output | 1 | Field identity of the last word |
| sd_comp_o | output | 1 | SD composite format flag |
| valid_o | output | 1 | One-clock strobe for a recognised word |

## Verification
The interaction that matters most is a vertical sync falling edge that arrives in the same clock as a horizontal sync falling edge. The word restarts on that edge, and that same line edge must not count toward the third-edge rule. The bench sends two 1080I fields in which both sync inputs fall on the same clock edge. The data bits are still placed according to the rule above. If the design counted the shared edge, the word would shift by one line and decode as unknown, which the scoreboard catches as a missing valid strobe and the wrong count.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [3:0] {
    FMT_NONE  = 4'd0,
    FMT_525I  = 4'd1,
    FMT_625I  = 4'd2,
    FMT_480P  = 4'd3,
    FMT_576P  = 4'd4,
    FMT_720P  = 4'd5,
    FMT_1080I = 4'd6,
    FMT_1080P = 4'd7
  } fmt_e;

  localparam int NUM_FMT = 7;

  typedef struct packed {
    logic [10:0] odd_cnt;
    logic [10:0] even_cnt;
    logic        interlaced;
    fmt_e        code;
  } fmt_entry_t;

  function automatic fmt_entry_t fmt_entry(input int idx);
    fmt_entry_t e;
    case (idx)
      0:       e = '{11'd260,  11'd259,  1'b1, FMT_525I};
      1:       e = '{11'd310,  11'd309,  1'b1, FMT_625I};
      2:       e = '{11'd522,  11'd522,  1'b0, FMT_480P};
      3:       e = '{11'd622,  11'd622,  1'b0, FMT_576P};
      4:       e = '{11'd747,  11'd747,  1'b0, FMT_720P};
      5:       e = '{11'd560,  11'd559,  1'b1, FMT_1080I};
      default: e = '{11'd1122, 11'd1122, 1'b0, FMT_1080P};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/vfd_line_timer.sv
module vfd_line_timer #(
  parameter int PER_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_ni,
  input  logic vsync_ni,
  input  logic data_i,
  output logic hs_edge_o,
  output logic vs_edge_o,
  output logic mid_o,
  output logic data_o
);
  logic [1:0]       hs_q, vs_q;
  logic             d_q;
  logic [PER_W-1:0] per_cnt, mid_cnt;
  logic [PER_W-1:0] per_len;
  logic             armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 2'b11;
      vs_q <= 2'b11;
      d_q  <= 1'b0;
    end else begin
      hs_q <= {hs_q[0], hsync_ni};
      vs_q <= {vs_q[0], vsync_ni};
      d_q  <= data_i;
    end
  end

  assign hs_edge_o = hs_q[1] & ~hs_q[0];
  assign vs_edge_o = vs_q[1] & ~vs_q[0];
  assign data_o    = d_q;
  assign mid_o     = armed && (mid_cnt == '0);

  // completed period length, saturating
  always_comb per_len = (&per_cnt) ? per_cnt : per_cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt <= '0;
      mid_cnt <= '0;
      armed   <= 1'b0;
    end else if (hs_edge_o) begin
      per_cnt <= '0;
      mid_cnt <= per_len >> 1;
      armed   <= 1'b1;
    end else begin
      if (!(&per_cnt)) per_cnt <= per_cnt + 1'b1;
      if (armed) begin
        if (mid_cnt == '0) armed <= 1'b0;
        else               mid_cnt <= mid_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfd_word_capture.sv
module vfd_word_capture #(
  parameter int CNT_W      = 11,
  parameter int FIRST_EDGE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_edge_i,
  input  logic             vs_edge_i,
  input  logic             mid_i,
  input  logic             data_i,
  output logic [CNT_W-1:0] word_o,
  output logic             done_o
);
  localparam int LAST_EDGE = FIRST_EDGE + CNT_W - 1;
  localparam int EDGE_W    = $clog2(LAST_EDGE + 2);
  localparam int BIT_W     = $clog2(CNT_W + 1);

  logic [EDGE_W-1:0] edge_cnt, edge_nxt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  shreg;
  logic              take, active, done;

  always_comb edge_nxt = edge_cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      take     <= 1'b0;
      active   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (vs_edge_i) begin
        // a coincident line edge is deliberately not counted
        edge_cnt <= '0;
        bit_cnt  <= '0;
        take     <= 1'b0;
        active   <= 1'b1;
      end else if (hs_edge_i && active) begin
        edge_cnt <= edge_nxt;
        take     <= (edge_nxt >= EDGE_W'(FIRST_EDGE)) && (edge_nxt <= EDGE_W'(LAST_EDGE));
      end else if (mid_i && take) begin
        shreg   <= {shreg[CNT_W-2:0], data_i};
        take    <= 1'b0;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_W'(CNT_W - 1)) begin
          done   <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end

  assign word_o = shreg;
  assign done_o = done;
endmodule

// File: rtl/vfd_classify.sv
module vfd_classify
  import vfd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] word_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] count_o,
  output fmt_e             fmt_o,
  output logic             field_o,
  output logic             sd_o,
  output logic             valid_o
);
  fmt_e code_c, cand;
  logic field_c;

  always_comb begin
    code_c  = FMT_NONE;
    field_c = 1'b0;
    for (int i = 0; i < NUM_FMT; i++) begin
      fmt_entry_t e;
      int w;
      e = fmt_entry(i);
      w = int'(word_i);
      if (w >= int'(e.even_cnt) - TOL && w <= int'(e.odd_cnt) + TOL) begin
        code_c  = e.code;
        field_c = e.interlaced ? (w >= int'(e.odd_cnt)) : 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      fmt_o   <= FMT_NONE;
      cand    <= FMT_NONE;
      field_o <= 1'b0;
      sd_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        count_o <= word_i;
        field_o <= field_c;
        sd_o    <= word_i[CNT_W-3];
        valid_o <= (code_c != FMT_NONE);
        cand    <= code_c;
        if (code_c == cand) fmt_o <= code_c;
      end
    end
  end
endmodule

// File: rtl/vfd_decoder.sv
module vfd_decoder
  import vfd_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int PER_W      = 16,
  parameter int FIRST_EDGE = 3,
  parameter int TOL        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_ni,
  input  logic             vsync_ni,
  input  logic             data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [3:0]       fmt_o,
  output logic             field_o,
  output logic             sd_comp_o,
  output logic             valid_o
);
  logic             hs_edge, vs_edge, mid, data_q, word_done;
  logic [CNT_W-1:0] word;
  fmt_e             fmt;

  vfd_line_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .hsync_ni, .vsync_ni, .data_i,
    .hs_edge_o(hs_edge), .vs_edge_o(vs_edge), .mid_o(mid), .data_o(data_q)
  );

  vfd_word_capture #(.CNT_W(CNT_W), .FIRST_EDGE(FIRST_EDGE)) u_cap (
    .clk_i, .rst_ni, .hs_edge_i(hs_edge), .vs_edge_i(vs_edge), .mid_i(mid),
    .data_i(data_q), .word_o(word), .done_o(word_done)
  );

  vfd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .clk_i, .rst_ni, .word_i(word), .done_i(word_done),
    .count_o, .fmt_o(fmt), .field_o, .sd_o(sd_comp_o), .valid_o
  );

  assign fmt_o = fmt;
endmodule

// File: rtl/vfd_decoder_chk.sv
module vfd_decoder_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_done_i,
  input logic             valid_i,
  input logic [3:0]       fmt_i,
  input logic [CNT_W-1:0] count_i,
  input logic             field_i
);
  p_valid_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_valid_after_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(word_done_i));

  p_fmt_only_on_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fmt_i) |-> $past(word_done_i));

  p_count_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_done_i) |-> $stable(count_i));

  p_progressive_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (count_i == 11'd522 || count_i == 11'd622 ||
                 count_i == 11'd747 || count_i == 11'd1122)) |-> field_i);
endmodule

bind vfd_decoder vfd_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_done_i(word_done), .valid_i(valid_o),
  .fmt_i(fmt_o), .count_i(count_o), .field_i(field_o)
);

// File: tb/sim_vfd_decoder.sv
module sim_vfd_decoder;
  localparam int LINE   = 40;
  localparam int HS_LOW = 4;

  typedef struct {
    int   cnt;
    int   fmt;
    logic field;
    logic sd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_ni = 1'b1, vsync_ni = 1'b1, data_i = 1'b0;
  logic [10:0] count_o;
  logic [3:0]  fmt_o;
  logic        field_o, sd_comp_o, valid_o;

  int   checks = 0, errors = 0;
  bit   finished = 0;
  exp_t q[$];
  int   cand = 0, conf = 0;

  always #4 clk = ~clk;

  vfd_decoder u0 (
    .clk_i(clk), .rst_ni, .hsync_ni, .vsync_ni, .data_i,
    .count_o, .fmt_o, .field_o, .sd_comp_o, .valid_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // decode model built from R4/R5
  task automatic model(input int w, output int code, output logic fld);
    code = 0; fld = 1'b0;
    if (w >= 257 && w <= 262)        begin code = 1; fld = (w >= 260); end
    else if (w >= 307 && w <= 312)   begin code = 2; fld = (w >= 310); end
    else if (w >= 520 && w <= 524)   begin code = 3; fld = 1'b1; end
    else if (w >= 620 && w <= 624)   begin code = 4; fld = 1'b1; end
    else if (w >= 745 && w <= 749)   begin code = 5; fld = 1'b1; end
    else if (w >= 557 && w <= 562)   begin code = 6; fld = (w >= 560); end
    else if (w >= 1120 && w <= 1124) begin code = 7; fld = 1'b1; end
  endtask

  // vs_mode: 0 none, 1 vsync falls with hsync, 2 vsync falls late in line, 3 vsync rises
  task automatic drive_line(input logic d, input int vs_mode);
    @(negedge clk);
    hsync_ni = 1'b0;
    data_i   = d;
    if (vs_mode == 1) vsync_ni = 1'b0;
    if (vs_mode == 3) vsync_ni = 1'b1;
    for (int c = 1; c < LINE; c++) begin
      @(negedge clk);
      if (c == HS_LOW) hsync_ni = 1'b1;
      if (vs_mode == 2 && c == (LINE * 3) / 4) vsync_ni = 1'b0;
    end
  endtask

  task automatic run_field(input int w, input bit coincide);
    int   code;
    logic fld;
    logic [10:0] wv;
    exp_t e;
    wv = 11'(w);
    model(w, code, fld);
    if (code == cand) conf = code;
    cand = code;
    if (code != 0) begin
      e.cnt = w; e.fmt = conf; e.field = fld; e.sd = wv[8];
      q.push_back(e);
    end
    drive_line(1'b0, coincide ? 1 : 2);
    for (int n = 1; n <= 16; n++)
      drive_line((n >= 3 && n <= 13) ? wv[13 - n] : 1'b0, (n == 3) ? 3 : 0);
    chk(count_o == wv, "R2", "count after field", int'(count_o), w);
    chk(int'(fmt_o) == conf, "R7", "confirmed format", int'(fmt_o), conf);
    chk(field_o == fld, "R5", "field id", int'(field_o), int'(fld));
    chk(sd_comp_o == wv[8], "R9", "sd flag", int'(sd_comp_o), int'(wv[8]));
    chk(q.size() == 0, "R6", "pending strobes", q.size(), 0);
  endtask

  // monitor: every valid strobe must match a queued item
  initial begin
    forever begin
      @(negedge clk);
      if (valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6", "unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(count_o) == e.cnt, "R8", "count at valid", int'(count_o), e.cnt);
          chk(int'(fmt_o) == e.fmt, "R4", "format at valid", int'(fmt_o), e.fmt);
          chk(field_o == e.field, "R5", "field at valid", int'(field_o), int'(e.field));
          chk(sd_comp_o == e.sd, "R9", "sd at valid", int'(sd_comp_o), int'(e.sd));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(count_o == 11'd0, "R1", "count in reset", int'(count_o), 0);
    chk(fmt_o == 4'd0, "R1", "fmt in reset", int'(fmt_o), 0);
    chk(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(field_o == 1'b0 && sd_comp_o == 1'b0, "R1", "field/sd after reset",
        int'({field_o, sd_comp_o}), 0);
    // idle lines so the line period is measured (R3)
    repeat (3) drive_line(1'b0, 0);
    // table entries, paired fields (R3, R4)
    run_field(260, 0);  run_field(259, 0);
    run_field(310, 0);  run_field(309, 0);
    run_field(522, 0);  run_field(522, 0);
    run_field(622, 0);  run_field(622, 0);
    run_field(747, 0);  run_field(747, 0);
    run_field(560, 0);  run_field(559, 0);
    run_field(1122, 0); run_field(1122, 0);
    // tolerance edges (R5)
    run_field(262, 0);  run_field(257, 0);
    // single glitch field must not change the format (R7)
    run_field(624, 0);  run_field(1120, 0);
    // out of range, twice, format goes unknown (R6, R7)
    run_field(263, 0);  run_field(1125, 0);
    run_field(1124, 0);
    // vsync and hsync falling together (R2)
    run_field(560, 1);  run_field(559, 1);
    chk(fmt_o == 4'd6, "R2", "format after coincident edges", int'(fmt_o), 6);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule